// File: doc/BRIEF.md
# I2C Slave Transmitter

This block is the part of a two-wire bus controller that answers a master's read request. It watches SCL and SDA for START and STOP conditions and collects the first byte after a START. When that byte carries the local address with the read bit, it pulls SDA low for the acknowledge. It then raises an interrupt flag with a status code and holds SCL low until the host hands it a byte to send. Each byte goes out MSB first. After every byte the block samples the master's acknowledge and reports the outcome with a fresh status code.

The local address comes from an 8-bit setting whose upper seven bits are the address. When its top five bits read 11110, the block uses a two-byte address. The first byte is acknowledged quietly, and the flag rises only after the second byte also matches. A separate pulse input tells the block that the master side of the controller has just lost arbitration during its own address phase. A match that follows is reported with its own code.

Bytes enter on a valid/ready port. `tx_ready` is high only while the flag is up and the block is waiting for data. A byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high. Taking the byte lowers the flag and releases SCL. `tx_valid` may be held high for any length of time without loss, because nothing is taken while `tx_ready` is low.

Top module: `i2cst_slave_tx`

## Requirements
- R1: After reset, `int_flag` is 0, `status` is F8h, `tx_ready` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: The first byte after a START matches in 7-bit mode when bits [7:1] equal `own_addr[7:1]` and bit 0 (the read bit) is 1. On a match the block drives SDA low during the 9th clock. After that clock's falling edge it sets `int_flag` with status A8h.
- R3: A first byte whose address differs, or whose bit 0 is 0 (a write), gets no acknowledge. In that case `int_flag` stays 0 and `status` stays F8h.
- R4: Extended mode is selected when `own_addr[7:3]` is 11110. The matching first byte is acknowledged without setting the flag, without changing `status` and without holding SCL. A second byte equal to `ext_addr` is then acknowledged and sets the flag with A8h. A second byte that differs is not acknowledged.
- R5: A pulse on `arb_lost` between a START and the final address match makes that match report B0h instead of A8h.
- R6: While the block waits for data, it holds SCL low (`scl_oe` = 1) and `tx_ready` is 1. Accepting a byte clears `int_flag` and releases SCL.
- R7: Data bits leave MSB first, and `sda_oe` changes only while SCL is low.
- R8: When the master acknowledges a byte (SDA low in the 9th clock), the block sets `int_flag` with status B8h and again holds SCL low.
- R9: When the master does not acknowledge a byte, the block sets `int_flag` with status C0h and releases SCL and SDA. A `flag_clr` pulse then clears `int_flag` and leaves `status` at C0h.
- R10: A STOP, or any START, clears `int_flag`, sets `status` to F8h and releases both lines. A START also begins a new address byte.
- R11: `flag_clr` has no effect while the block waits for data. The flag and the SCL hold both remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 8 | Local address in [7:1]; 11110 in [7:3] selects two-byte addressing |
| ext_addr | input | 8 | Expected second address byte in extended mode |
| arb_lost | input | 1 | Pulse: master side lost arbitration during its address phase |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_ready | output | 1 | Block can take a byte |
| flag_clr | input | 1 | Clears the flag after a not-acknowledged byte |
| int_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. Its bus master uses a half-period of 8 clocks, which is several times the latency from a line change to a decision. This leaves the sampling margins wide while still exercising stretch release and the acknowledge handover within a few cycles of each SCL edge. Transactions in both address modes, with and without the arbitration pulse, are mixed with mismatching and write-direction addresses. They are closed by either a STOP or a repeated START.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [7:0] ST_IDLE    = 8'hF8;
  localparam logic [7:0] ST_SLA_RD  = 8'hA8;
  localparam logic [7:0] ST_ARB_RD  = 8'hB0;
  localparam logic [7:0] ST_TX_ACK  = 8'hB8;
  localparam logic [7:0] ST_TX_NACK = 8'hC0;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR1, PH_ACK1, PH_ADDR2, PH_ACK2,
    PH_WAIT, PH_SHIFT, PH_MACK, PH_DONE
  } phase_t;
endpackage

// File: rtl/i2cst_line_mon.sv
module i2cst_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] ln_in;
  logic [1:0] ln_s;
  logic       scl_d, sda_d;

  assign ln_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [STAGES-1:0] sq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '1;
      else        sq <= {sq[STAGES-2:0], ln_in[g]};
    end
    assign ln_s[g] = sq[STAGES-1];
  end

  assign scl_s = ln_s[0];
  assign sda_s = ln_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cst_addr_cmp.sv
module i2cst_addr_cmp (
  input  logic [7:0] own_addr,
  input  logic [7:0] ext_addr,
  input  logic [7:0] rx_byte,
  input  logic       second,
  output logic       ext_mode,
  output logic       hit
);
  logic first_ok;

  assign ext_mode = (own_addr[7:3] == 5'b11110);
  assign first_ok = (rx_byte[7:1] == own_addr[7:1]) && rx_byte[0];
  assign hit      = second ? (rx_byte == ext_addr) : first_ok;
endmodule

// File: rtl/i2cst_shifter.sv
module i2cst_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2cst_slave_tx.sv
module i2cst_slave_tx
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        own_addr,
  input  logic [7:0]        ext_addr,
  input  logic              arb_lost,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              flag_clr,
  output logic              int_flag,
  output logic [7:0]        status,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ext_mode, addr_hit, second;
  logic sh_load, sh_shift, sh_din;
  logic [BYTE_W-1:0] sh_q;
  phase_t ph;
  logic [CNT_W-1:0] bit_cnt;
  logic arb_flag, mack, take, rx_phase;

  i2cst_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign second = (ph == PH_ADDR2);

  i2cst_addr_cmp u_cmp (
    .own_addr(own_addr), .ext_addr(ext_addr), .rx_byte(sh_q),
    .second(second), .ext_mode(ext_mode), .hit(addr_hit)
  );

  assign tx_ready = int_flag && (ph == PH_WAIT);
  assign take     = tx_valid && tx_ready;
  assign rx_phase = (ph == PH_ADDR1) || (ph == PH_ADDR2);

  assign sh_load  = take;
  assign sh_shift = !start_det && !stop_det &&
                    ((rx_phase && scl_rise) || ((ph == PH_SHIFT) && scl_fall));
  assign sh_din   = rx_phase ? sda_s : 1'b0;

  i2cst_shifter #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(tx_byte),
    .shift(sh_shift), .din(sh_din), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bit_cnt  <= '0;
      int_flag <= 1'b0;
      status   <= ST_IDLE;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      arb_flag <= 1'b0;
      mack     <= 1'b0;
    end else begin
      if (arb_lost) arb_flag <= 1'b1;
      if (start_det || stop_det) begin
        ph       <= start_det ? PH_ADDR1 : PH_IDLE;
        bit_cnt  <= '0;
        int_flag <= 1'b0;
        status   <= ST_IDLE;
        scl_oe   <= 1'b0;
        sda_oe   <= 1'b0;
        arb_flag <= arb_lost;
      end else begin
        unique case (ph)
          PH_ADDR1, PH_ADDR2: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_FULL) begin
              bit_cnt <= '0;
              if (addr_hit) begin
                sda_oe <= 1'b1;
                ph     <= (ph == PH_ADDR1) ? PH_ACK1 : PH_ACK2;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          PH_ACK1, PH_ACK2: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (ph == PH_ACK1 && ext_mode) begin
                ph <= PH_ADDR2;
              end else begin
                ph       <= PH_WAIT;
                int_flag <= 1'b1;
                scl_oe   <= 1'b1;
                status   <= arb_flag ? ST_ARB_RD : ST_SLA_RD;
                arb_flag <= 1'b0;
              end
            end
          end
          PH_WAIT: begin
            if (take) begin
              int_flag <= 1'b0;
              scl_oe   <= 1'b0;
              sda_oe   <= ~tx_byte[BYTE_W-1];
              bit_cnt  <= '0;
              ph       <= PH_SHIFT;
            end
          end
          PH_SHIFT: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_LAST) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                ph      <= PH_MACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                sda_oe  <= ~sh_q[BYTE_W-2];
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              int_flag <= 1'b1;
              if (mack) begin
                status <= ST_TX_ACK;
                scl_oe <= 1'b1;
                ph     <= PH_WAIT;
              end else begin
                status <= ST_TX_NACK;
                ph     <= PH_DONE;
              end
            end
          end
          PH_DONE: begin
            if (flag_clr) int_flag <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cst_sva.sv
module i2cst_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       int_flag,
  input logic [7:0] status,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       flag_clr
);
  p_sda_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_ready_holds_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (int_flag && scl_oe));

  p_take_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!int_flag && !scl_oe && !tx_ready));

  p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!int_flag && !scl_oe && !sda_oe && status == 8'hF8));

  p_nack_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'hC0) |-> (!scl_oe && !tx_ready));

  p_flag_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> (status == 8'hA8 || status == 8'hB0 ||
                         status == 8'hB8 || status == 8'hC0));

  p_clr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && tx_ready && !tx_valid) |=> (int_flag && scl_oe));
endmodule

bind i2cst_slave_tx i2cst_sva u_sva (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .int_flag(int_flag), .status(status),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .flag_clr(flag_clr)
);

// File: tb/tb_i2cst_slave_tx.sv
module tb_i2cst_slave_tx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] own_addr = 8'h5A, ext_addr = 8'h3C, tx_byte = 8'h00, status;
  logic arb_lost = 1'b0, tx_valid = 1'b0, flag_clr = 1'b0;
  logic tx_ready, int_flag, scl_oe, sda_oe;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  int n_vec = 0, n_bad = 0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cst_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .ext_addr(ext_addr),
    .arb_lost(arb_lost), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .flag_clr(flag_clr), .int_flag(int_flag),
    .status(status), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic bit f_ext(input logic [7:0] own);
    return own[7:3] == 5'b11110;
  endfunction
  function automatic bit f_first_hit(input logic [7:0] own, input logic [7:0] b);
    return (b[7:1] == own[7:1]) && b[0];
  endfunction
  function automatic logic [7:0] f_entry(input bit arb);
    return arb ? 8'hB0 : 8'hA8;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wclk(H); scl_up(); wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wclk(H); scl_up(); wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic m_bit(input logic b, output logic seen);
    sda_m = b; wclk(H); scl_up(); wclk(H/2);
    seen = sda_line; wclk(H/2); scl_m = 1'b0; wclk(2);
  endtask

  task automatic m_send(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    acked = !s;
    wclk(4);
  endtask

  task automatic m_read(input bit ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
    m_bit(ack ? 1'b0 : 1'b1, s);
    sda_m = 1'b1;
    wclk(4);
  endtask

  task automatic cpu_push(input logic [7:0] b);
    int guard = 0;
    tx_byte = b; tx_valid = 1'b1;
    while (!tx_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!int_flag && !scl_oe, "R6 take clears flag/hold", {int_flag, scl_oe}, 0);
  endtask

  // one read transaction; last byte always not acknowledged
  task automatic run_txn(input bit arb, input logic [7:0] b1, input logic [7:0] b2,
                         input int nbytes, input bit end_rs);
    bit ack, hit1, hit2;
    logic [7:0] d, got;
    m_start();
    chk(status == 8'hF8 && !int_flag, "R10 start idles", status, 8'hF8);
    if (arb) begin arb_lost = 1'b1; wclk(1); arb_lost = 1'b0; end
    hit1 = f_first_hit(own_addr, b1);
    m_send(b1, ack);
    chk(ack == hit1, hit1 ? "R2 first byte acked" : "R3 first byte not acked", ack, hit1);
    if (!hit1) begin
      chk(!int_flag && status == 8'hF8, "R3 no flag", {int_flag, status}, 8'hF8);
      m_stop(); return;
    end
    if (f_ext(own_addr)) begin
      chk(!int_flag && status == 8'hF8 && !scl_oe, "R4 quiet first byte",
          {int_flag, scl_oe, status}, 8'hF8);
      hit2 = (b2 == ext_addr);
      m_send(b2, ack);
      chk(ack == hit2, "R4 second byte ack", ack, hit2);
      if (!hit2) begin
        chk(!int_flag, "R4 no flag on miss", int_flag, 0);
        m_stop(); return;
      end
    end
    chk(int_flag && status == f_entry(arb), arb ? "R5 entry code" : "R2 entry code",
        status, f_entry(arb));
    chk(scl_oe && tx_ready, "R6 hold while waiting", {scl_oe, tx_ready}, 3);
    flag_clr = 1'b1; wclk(1); flag_clr = 1'b0; wclk(1);
    chk(int_flag && scl_oe, "R11 clear ignored while waiting", {int_flag, scl_oe}, 3);
    for (int k = 0; k < nbytes; k++) begin
      d = 8'($urandom);
      cpu_push(d);
      m_read(k != nbytes - 1, got);
      chk(got == d, "R7 byte MSB first", got, d);
      if (k != nbytes - 1) begin
        chk(int_flag && status == 8'hB8 && scl_oe, "R8 ack code and hold", status, 8'hB8);
      end else begin
        chk(int_flag && status == 8'hC0 && !scl_oe && !sda_oe, "R9 nack code and release",
            {int_flag, scl_oe, sda_oe, status}, {3'b100, 8'hC0});
        flag_clr = 1'b1; wclk(1); flag_clr = 1'b0; wclk(1);
        chk(!int_flag && status == 8'hC0, "R9 clear after nack", {int_flag, status}, 8'hC0);
      end
    end
    if (end_rs) begin
      m_start();
      chk(!int_flag && status == 8'hF8 && !sda_oe, "R10 repeated start idles", status, 8'hF8);
    end
    m_stop();
    wclk(4);
    chk(!int_flag && status == 8'hF8 && !scl_oe && !sda_oe, "R10 stop idles", status, 8'hF8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b1, b2;
    bit ack;
    void'($urandom(32'd1234));
    wclk(3);
    chk(!int_flag && status == 8'hF8 && !tx_ready && !scl_oe && !sda_oe, "R1 reset state",
        {int_flag, tx_ready, scl_oe, sda_oe, status}, 8'hF8);
    rst_n = 1'b1; wclk(4);

    own_addr = 8'h5A;
    run_txn(0, 8'h5B, 8'h00, 3, 0);          // 7-bit read
    run_txn(0, 8'h5A, 8'h00, 1, 0);          // write bit: R3
    run_txn(0, 8'h13, 8'h00, 1, 0);          // other address: R3
    run_txn(1, 8'h5B, 8'h00, 1, 1);          // arbitration entry: R5
    tx_valid = 1'b1; tx_byte = 8'hFF; wclk(20);
    chk(!int_flag && !scl_oe, "R6 valid ignored while idle", {int_flag, scl_oe}, 0);
    tx_valid = 1'b0;

    own_addr = 8'hF4; ext_addr = 8'h3C;
    run_txn(0, 8'hF5, 8'h3C, 2, 0);          // extended read: R4
    run_txn(1, 8'hF5, 8'h3C, 1, 1);          // extended with arbitration: R5
    run_txn(0, 8'hF5, 8'h3D, 1, 0);          // second byte mismatch: R4
    // STOP between the two address bytes: R10
    m_start(); m_send(8'hF5, ack); m_stop(); wclk(4);
    chk(!int_flag && status == 8'hF8 && !sda_oe, "R10 stop mid address", status, 8'hF8);

    for (int t = 0; t < 40; t++) begin
      bit ext_m = $urandom_range(0, 1) == 1;
      own_addr = ext_m ? {5'b11110, 3'($urandom)} : 8'($urandom);
      if (!ext_m && own_addr[7:3] == 5'b11110) own_addr[7] = 1'b0;
      ext_addr = 8'($urandom);
      b1 = ($urandom_range(0, 9) < 7) ? {own_addr[7:1], 1'b1} : 8'($urandom);
      b2 = ($urandom_range(0, 9) < 8) ? ext_addr : 8'($urandom);
      run_txn($urandom_range(0, 3) == 0, b1, b2, $urandom_range(1, 4),
              $urandom_range(0, 1) == 1);
    end
    finish_run();
  end
endmodule